// File: doc/BRIEF.md
# Paged Program Counter with Two-Level Return Stack

This unit sequences instruction fetch for a small core with 12-bit instruction words. It holds the program counter and presents it as the fetch address. Each clock cycle the decoder selects one operation: advance by one, jump, call a subroutine, return, write the low counter bits directly, or stay. The `PC_W` parameter sets the counter to 9, 10 or 11 bits, which gives 512, 1024 or 2048 words of program space.

Program space above 512 words is divided into 512-word pages. On a jump, call or direct write, the counter bits above bit 8 come from one or two page-select bits supplied by the status register. A two-entry return stack holds return addresses for calls. It never reports overflow: a third nested call overwrites the oldest entry.

After reset the counter points at the last word of program space. When that word holds a no-operation, the following fetch wraps to address 000h. A hold input freezes the counter and the stack for one cycle, which covers the flush slot after a taken branch.

Top module: `prog_seq`

## Requirements
- R1: When reset is asserted, `fetch_addr` becomes the highest address 2^PC_W-1 (7FFh for the default PC_W=11) and both stack levels clear.
- R2: The increment operation (op 0) adds one modulo 2^PC_W, so incrementing from the highest address gives 000h.
- R3: The jump operation (op 1) loads counter bits 8..0 from `imm[8:0]`. Bit 9 comes from `page_sel[0]` and bit 10 from `page_sel[1]`. Page-select bits at or above PC_W have no effect.
- R4: The call operation (op 2) pushes (counter+1) modulo 2^PC_W and loads {page bits, 0, `imm[7:0]`}. Bit 8 of the target is always 0 and `imm[8]` has no effect.
- R5: The return operation (op 3) loads the counter from stack level 1 and copies level 2 into level 1. Level 2 keeps its value, so repeated returns keep giving the same address.
- R6: Each push moves level 1 into level 2 before writing level 1. A third nested push loses the oldest address, and no flag is produced.
- R7: The direct-write operation (op 4) loads {page bits, 0, `imm[7:0]`} and leaves the stack unchanged.
- R8: The stay operation (op 5) leaves the counter and the stack unchanged.
- R9: When `hold` is 1, the counter and the stack keep their values whatever `op` is.
- R10: The unused op codes 6 and 7 behave as stay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 3 | Operation code for this cycle |
| imm | input | 9 | Immediate address field of the instruction, or the direct-write data |
| page_sel | input | 2 | Page-select bits from the status register |
| hold | input | 1 | Freezes the counter and the stack for this cycle |
| fetch_addr | output | PC_W | Current program counter, used as the fetch address |

## Verification
The bench targets the points where a paged sequencer usually breaks.

- **Wrap from the top word.** The increment from the reset vector must reach 000h. A counter that saturated, or did not wrap, would stick at the top word or fetch beyond the implemented space.
- **Call target bit 8 and the pushed address.** Calls are issued with `imm[8]` set, and one call is made from the top address. A design that let `imm[8]` through would send the call into the upper half of the page. A design that pushed an unwrapped address would return beyond the implemented space.
- **Stack overflow and repeated returns.** Three nested calls are followed by three returns. The oldest address must be gone, and the last two returns must give the same address. A stack that shifted in zeros or rotated its entries would produce a different sequence.
- **Hold during a call.** A call issued under hold must push nothing. A stack that pushed anyway would show up on the following return.

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int PC_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op,
  input  logic [8:0]      imm,
  input  logic [1:0]      page_sel,
  input  logic            hold,
  output logic [PC_W-1:0] fetch_addr
);

  localparam logic [2:0] OP_INC  = 3'd0;
  localparam logic [2:0] OP_JMP  = 3'd1;
  localparam logic [2:0] OP_CALL = 3'd2;
  localparam logic [2:0] OP_RET  = 3'd3;
  localparam logic [2:0] OP_WR   = 3'd4;
  localparam logic [PC_W-1:0] TOP = '1;

  logic [PC_W-1:0] pc_q, lvl1_q, lvl2_q;
  logic [PC_W-1:0] pc_d, lvl1_d, lvl2_d;
  logic [PC_W-1:0] pc_inc, jmp_tgt, near_tgt;

  assign pc_inc   = pc_q + 1'b1;
  assign jmp_tgt  = PC_W'({page_sel, imm});
  assign near_tgt = PC_W'({page_sel, 1'b0, imm[7:0]});

  always_comb begin
    pc_d   = pc_q;
    lvl1_d = lvl1_q;
    lvl2_d = lvl2_q;
    if (!hold) begin
      case (op)
        OP_INC:  pc_d = pc_inc;
        OP_JMP:  pc_d = jmp_tgt;
        OP_CALL: begin
          pc_d   = near_tgt;
          lvl2_d = lvl1_q;
          lvl1_d = pc_inc;
        end
        OP_RET: begin
          pc_d   = lvl1_q;
          lvl1_d = lvl2_q;
        end
        OP_WR:   pc_d = near_tgt;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= TOP;
      lvl1_q <= '0;
      lvl2_q <= '0;
    end else begin
      pc_q   <= pc_d;
      lvl1_q <= lvl1_d;
      lvl2_q <= lvl2_d;
    end
  end

  assign fetch_addr = pc_q;

  // R2
  wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC && !hold && pc_q == TOP) |=> (pc_q == '0));

  // R3
  jmp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JMP && !hold) |=> (pc_q[8:0] == $past(imm)));

  // R4
  call_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CALL && !hold) |=>
      (pc_q[8] == 1'b0 && lvl1_q == PC_W'($past(pc_q) + 1'b1) && lvl2_q == $past(lvl1_q)));

  // R5
  ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RET && !hold) |=>
      (pc_q == $past(lvl1_q) && lvl1_q == $past(lvl2_q) && $stable(lvl2_q)));

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(pc_q) && $stable(lvl1_q) && $stable(lvl2_q)));

  // R8
  stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd5) |=> $stable(pc_q));

endmodule

// File: tb/prog_seq_tb.sv
module prog_seq_tb;
  localparam int PC_W = 11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      op = 3'd5;
  logic [8:0]      imm = '0;
  logic [1:0]      page_sel = '0;
  logic            hold = 1'b0;
  logic [PC_W-1:0] fetch_addr;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  prog_seq #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .imm(imm),
    .page_sel(page_sel), .hold(hold), .fetch_addr(fetch_addr)
  );

  // {op[2:0], imm[8:0], page[1:0], hold, expected[10:0]}
  localparam int NV = 19;
  localparam logic [25:0] VEC [NV] = '{
    {3'd0, 9'h000, 2'd0, 1'b0, 11'h000},  // R2 wrap from reset vector
    {3'd0, 9'h000, 2'd0, 1'b0, 11'h001},  // R2
    {3'd1, 9'h1A5, 2'd2, 1'b0, 11'h5A5},  // R3
    {3'd2, 9'h1F3, 2'd1, 1'b0, 11'h2F3},  // R4 imm[8] ignored, push 5A6
    {3'd2, 9'h010, 2'd3, 1'b0, 11'h610},  // R4 push 2F4
    {3'd2, 9'h020, 2'd0, 1'b0, 11'h020},  // R6 push 611, 5A6 lost
    {3'd3, 9'h000, 2'd0, 1'b0, 11'h611},  // R5
    {3'd3, 9'h000, 2'd0, 1'b0, 11'h2F4},  // R5
    {3'd3, 9'h000, 2'd0, 1'b0, 11'h2F4},  // R6 oldest gone, repeat
    {3'd4, 9'h1C8, 2'd3, 1'b0, 11'h6C8},  // R7
    {3'd5, 9'h000, 2'd0, 1'b0, 11'h6C8},  // R8
    {3'd7, 9'h0AA, 2'd1, 1'b0, 11'h6C8},  // R10
    {3'd6, 9'h055, 2'd2, 1'b0, 11'h6C8},  // R10
    {3'd1, 9'h000, 2'd0, 1'b1, 11'h6C8},  // R9 jump held
    {3'd2, 9'h033, 2'd1, 1'b1, 11'h6C8},  // R9 call held
    {3'd3, 9'h000, 2'd0, 1'b0, 11'h2F4},  // R9 nothing pushed
    {3'd1, 9'h1FF, 2'd3, 1'b0, 11'h7FF},  // R3
    {3'd0, 9'h000, 2'd0, 1'b0, 11'h000},  // R2
    {3'd2, 9'h1FF, 2'd3, 1'b0, 11'h6FF}   // R4
  };

  task automatic check(input logic [PC_W-1:0] exp, input string req);
    n_tests++;
    if (fetch_addr !== exp) begin
      n_fail++;
      $display("FAIL %s: fetch_addr=%h expected=%h", req, fetch_addr, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [8:0] i,
                      input logic [1:0] p, input logic h);
    op = o; imm = i; page_sel = p; hold = h;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected=<5000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(11'h7FF, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(11'h7FF, "R1 held by stay");

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][25:23], VEC[k][22:14], VEC[k][13:12], VEC[k][11]);
      check(VEC[k][10:0], $sformatf("vector %0d R2-R10 table", k));
    end
    step(3'd3, 9'h000, 2'd0, 1'b0);
    check(11'h001, "R4 pushed address after call");

    // R1: reset mid-run
    op = 3'd5;
    rst_n = 1'b0;
    @(negedge clk);
    check(11'h7FF, "R1 reset mid-run");
    rst_n = 1'b1;

    // R4: push from the top word wraps to 000h
    step(3'd2, 9'h105, 2'd0, 1'b0);
    check(11'h005, "R4 call from top");
    step(3'd3, 9'h000, 2'd0, 1'b0);
    check(11'h000, "R4 pushed address wraps");

    // R5: after reset the stack is clear
    step(3'd3, 9'h000, 2'd0, 1'b0);
    check(11'h000, "R5 repeated return");

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule